// File: doc/BRIEF.md
# Vector Lane Permute and Extract Unit

This block is a purely combinational lane-permutation stage for a vector datapath. A vector operand carries sixteen 32-bit lanes. Two operations are decoded from an operation code. In the shuffle operation, each destination lane reads the source lane whose number sits in the same lane of a second vector operand. In the extract operation, one source lane is copied to a scalar result. The lane number for an extract comes from a scalar operand or, when the immediate-select flag is set, from the immediate operand.

All destination lanes of a shuffle are formed in parallel by independent selectors, so any source lane may appear in any number of destination lanes. Lane numbers are taken modulo the lane count. Any other operation code is reported as illegal, and both results are then forced to zero. The unit sits between operand read and write-back. It has no state, so its results are valid in the same cycle as its operands.

Top module: `vperm_unit`

## Requirements
- R1: With operation code 24 (shuffle), result lane i (bits 32*i+31 down to 32*i) equals source lane n, where n is the value of index lane i.
- R2: For shuffle, only bits 3:0 of each index lane are used, so an index lane value v selects source lane v mod 16, whatever its upper 28 bits hold.
- R3: With operation code 25 (extract) and the immediate-select flag low, the scalar result equals source lane scalarIdx mod 16, and immIdx has no effect.
- R4: With operation code 25 and the immediate-select flag high, the scalar result equals source lane immIdx mod 16, and scalarIdx has no effect.
- R5: For extract, bits above 3 of whichever lane number is selected have no effect on the result.
- R6: During a shuffle the scalar result is zero, and during an extract the result vector is zero.
- R7: For any operation code other than 24 or 25, illegalOp is 1 and both results are zero. For codes 24 and 25, illegalOp is 0.
- R8: The same source lane may feed several destination lanes of one shuffle, including all sixteen.
- R9: The immediate-select flag has no effect on a shuffle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 6 | Operation code: 24 shuffle, 25 extract |
| immSel | input | 1 | Extract takes its lane number from immIdx when 1 |
| srcVec | input | 512 | Source vector, lane i at bits 32*i+31:32*i |
| idxVec | input | 512 | Per-lane index vector for shuffle |
| scalarIdx | input | 32 | Register lane number for extract |
| immIdx | input | 32 | Immediate lane number for extract |
| resVec | output | 512 | Shuffle result vector |
| resScalar | output | 32 | Extract result |
| illegalOp | output | 1 | Operation code not supported |

## Verification
The bench drives several index patterns: identity, reversal, rotation, a full broadcast of one lane, and patterns whose upper index bits are filled with junk. A design that used too many index bits would index out of range or return the wrong lane. Extract is swept over every lane in both the register and immediate forms, with the unselected lane number set to a conflicting value, so a swapped or ignored select shows up as a wrong word. All 64 operation codes are applied; a decoder that leaks data on illegal codes, or leaves the unused result nonzero, is flagged on the zero-output checks.

// File: rtl/vperm_pkg.sv
package vperm_pkg;
  localparam int unsigned OP_W = 6;
  localparam logic [OP_W-1:0] OPC_SHUFFLE = 6'd24;
  localparam logic [OP_W-1:0] OPC_GETLANE = 6'd25;

  typedef struct packed {
    logic doShuffle;
    logic doGetlane;
    logic useImm;
    logic illegal;
  } vpermCtrl_t;
endpackage

// File: rtl/vperm_ctrl.sv
module vperm_ctrl
  import vperm_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  input  logic            immSel,
  output vpermCtrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (opCode)
      OPC_SHUFFLE: ctrl.doShuffle = 1'b1;
      OPC_GETLANE: begin
        ctrl.doGetlane = 1'b1;
        ctrl.useImm    = immSel;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end

  always_comb begin
    AST_ONE_MODE: assert ($onehot({ctrl.doShuffle, ctrl.doGetlane, ctrl.illegal})) // R7
      else $error("operation strobes not one-hot");
    AST_IMM_ONLY_EXTRACT: assert (!ctrl.useImm || ctrl.doGetlane) // R9
      else $error("immediate select leaked outside extract");
  end
endmodule

// File: rtl/vperm_lane_sel.sv
module vperm_lane_sel #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned ELEM_W = 32,
  localparam int unsigned IDX_W = $clog2(LANES)
) (
  input  logic [LANES*ELEM_W-1:0] srcVec,
  input  logic [IDX_W-1:0]        sel,
  output logic [ELEM_W-1:0]       laneOut
);
  always_comb begin
    laneOut = '0;
    for (int k = 0; k < LANES; k++) begin
      if (sel == IDX_W'(k)) laneOut = srcVec[k*ELEM_W +: ELEM_W];
    end
  end
endmodule

// File: rtl/vperm_datapath.sv
module vperm_datapath
  import vperm_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned ELEM_W = 32,
  localparam int unsigned IDX_W = $clog2(LANES)
) (
  input  vpermCtrl_t              ctrl,
  input  logic [LANES*ELEM_W-1:0] srcVec,
  input  logic [LANES*ELEM_W-1:0] idxVec,
  input  logic [ELEM_W-1:0]       scalarIdx,
  input  logic [ELEM_W-1:0]       immIdx,
  output logic [LANES*ELEM_W-1:0] resVec,
  output logic [ELEM_W-1:0]       resScalar
);
  logic [LANES*ELEM_W-1:0] shufRaw;
  logic [ELEM_W-1:0]       extractRaw;
  logic [IDX_W-1:0]        extractSel;
  logic [LANES*(ELEM_W-IDX_W)-1:0] unusedIdxHi;
  logic unusedScalarHi;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [IDX_W-1:0] laneSel;
    assign laneSel = idxVec[i*ELEM_W +: IDX_W];
    assign unusedIdxHi[i*(ELEM_W-IDX_W) +: (ELEM_W-IDX_W)] = idxVec[i*ELEM_W+IDX_W +: (ELEM_W-IDX_W)];

    vperm_lane_sel #(.LANES(LANES), .ELEM_W(ELEM_W)) u_sel (
      .srcVec (srcVec),
      .sel    (laneSel),
      .laneOut(shufRaw[i*ELEM_W +: ELEM_W])
    );

    always_comb begin
      if (ctrl.doShuffle && laneSel == IDX_W'(i))
        AST_IDENTITY_LANE: assert (resVec[i*ELEM_W +: ELEM_W] == srcVec[i*ELEM_W +: ELEM_W]) // R1
          else $error("self-indexed lane %0d altered", i);
    end
  end

  assign extractSel     = ctrl.useImm ? immIdx[IDX_W-1:0] : scalarIdx[IDX_W-1:0];
  assign unusedScalarHi = ^{scalarIdx[ELEM_W-1:IDX_W], immIdx[ELEM_W-1:IDX_W], unusedIdxHi, ctrl.illegal};

  vperm_lane_sel #(.LANES(LANES), .ELEM_W(ELEM_W)) u_extract (
    .srcVec (srcVec),
    .sel    (extractSel),
    .laneOut(extractRaw)
  );

  assign resVec    = ctrl.doShuffle ? shufRaw : '0;
  assign resScalar = ctrl.doGetlane ? extractRaw : '0;

  always_comb begin
    AST_VEC_IDLE_ZERO: assert (ctrl.doShuffle || resVec == '0) // R6
      else $error("result vector nonzero outside shuffle");
    AST_SCALAR_IDLE_ZERO: assert (ctrl.doGetlane || resScalar == '0) // R6
      else $error("scalar result nonzero outside extract");
  end
endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
  import vperm_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned ELEM_W = 32,
  localparam int unsigned VEC_W = LANES * ELEM_W
) (
  input  logic [OP_W-1:0]   opCode,
  input  logic              immSel,
  input  logic [VEC_W-1:0]  srcVec,
  input  logic [VEC_W-1:0]  idxVec,
  input  logic [ELEM_W-1:0] scalarIdx,
  input  logic [ELEM_W-1:0] immIdx,
  output logic [VEC_W-1:0]  resVec,
  output logic [ELEM_W-1:0] resScalar,
  output logic              illegalOp
);
  vpermCtrl_t ctrl;

  vperm_ctrl u_ctrl (
    .opCode(opCode),
    .immSel(immSel),
    .ctrl  (ctrl)
  );

  vperm_datapath #(.LANES(LANES), .ELEM_W(ELEM_W)) u_dp (
    .ctrl     (ctrl),
    .srcVec   (srcVec),
    .idxVec   (idxVec),
    .scalarIdx(scalarIdx),
    .immIdx   (immIdx),
    .resVec   (resVec),
    .resScalar(resScalar)
  );

  assign illegalOp = ctrl.illegal;

  always_comb begin
    AST_ILLEGAL_QUIET: assert (!illegalOp || (resVec == '0 && resScalar == '0)) // R7
      else $error("illegal opcode produced data");
  end
endmodule

// File: tb/tb_vperm_unit.sv
module tb_vperm_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int EW = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [5:0]          opCode = 6'd0;
  logic                immSel = 1'b0;
  logic [LANES*EW-1:0] srcVec = '0;
  logic [LANES*EW-1:0] idxVec = '0;
  logic [EW-1:0]       scalarIdx = '0;
  logic [EW-1:0]       immIdx = '0;
  logic [LANES*EW-1:0] resVec;
  logic [EW-1:0]       resScalar;
  logic                illegalOp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  vperm_unit dut (
    .opCode(opCode), .immSel(immSel), .srcVec(srcVec), .idxVec(idxVec),
    .scalarIdx(scalarIdx), .immIdx(immIdx),
    .resVec(resVec), .resScalar(resScalar), .illegalOp(illegalOp)
  );

  function automatic logic [EW-1:0] srcLane(int k);
    return 32'hC0DE_0000 ^ (32'(k) * 32'h0101_0103) ^ 32'(k);
  endfunction

  function automatic logic [EW-1:0] idxVal(int p, int i);
    case (p)
      0: return 32'(i);
      1: return 32'(15 - i);
      2: return 32'((i + 3) % 16);
      3: return 32'd5;
      4: return 32'((i * 7) % 16) | (32'(i + 1) * 32'h1234_5670);
      default: return 32'((i * 11 + 2) % 16) | 32'hFFFF_FFF0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    for (int k = 0; k < LANES; k++) srcVec[k*EW +: EW] = srcLane(k);

    // R7: opcode 0 is illegal from the start
    @(negedge clk);
    check(illegalOp === 1'b1 && resVec === '0 && resScalar === '0, "R7 initial",
          {illegalOp, resScalar}, 512'h1_00000000);

    // R1 R2 R8 R9: shuffle patterns
    for (int p = 0; p < 6; p++) begin
      logic [LANES*EW-1:0] exp;
      @(posedge clk);
      opCode = 6'd24;
      immSel = (p == 5);
      for (int i = 0; i < LANES; i++) begin
        idxVec[i*EW +: EW] = idxVal(p, i);
        exp[i*EW +: EW] = srcLane(int'(idxVal(p, i) % 16));
      end
      @(negedge clk);
      check(resVec === exp, (p == 3) ? "R8 broadcast" : (p >= 4) ? "R2 R9 high bits" : "R1 shuffle",
            resVec, exp);
      check(resScalar === '0 && illegalOp === 1'b0, "R6 R7 shuffle scalar zero",
            {illegalOp, resScalar}, 512'h0);
    end

    // R3 R5: register form; R4: immediate form
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < LANES; k++) begin
        @(posedge clk);
        opCode = 6'd25;
        immSel = (m == 1);
        if (m == 0) begin
          scalarIdx = 32'(k) + 32'(16 * (k + 1));
          immIdx = 32'(15 - k);
        end else begin
          immIdx = 32'(k) | 32'hABC0_0000;
          scalarIdx = 32'((k + 9) % 16);
        end
        @(negedge clk);
        check(resScalar === srcLane(k), (m == 0) ? "R3 R5 register extract" : "R4 R5 immediate extract",
              512'(resScalar), 512'(srcLane(k)));
        check(resVec === '0 && illegalOp === 1'b0, "R6 R7 extract vector zero",
              resVec, 512'h0);
      end
    end

    // R7: every unsupported code
    for (int c = 0; c < 64; c++) begin
      if (c == 24 || c == 25) continue;
      @(posedge clk);
      opCode = 6'(c);
      immSel = c[0];
      @(negedge clk);
      check(illegalOp === 1'b1 && resVec === '0 && resScalar === '0, "R7 illegal code",
            {illegalOp, resScalar}, 512'h1_00000000);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule